// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Sensing

This block is one general-purpose I/O port of a chip. Each of its pins can be driven as an output or read back as an input. Each pin can also raise an interrupt on a rising edge, a falling edge, a high level or a low level. Software reaches the block through a single-cycle register port. Every register answers at three aliases: a plain write, an OR-in set and a clear of the ones written. Software can therefore change one bit without reading the register first.

Pin levels enter through a two-flop synchronizer. A detector compares each synchronized sample with the one from the cycle before. A pin can reach its sticky status bit only when its route bit is set. Status bits stay set until software clears them. The single port interrupt is high while any status bit has its interrupt-enable bit set.

The word address is 6 bits wide. Bits [5:2] select the register and bits [1:0] select the alias, so the byte offset is four times the word address. The register indices are:

| Index | Register | Meaning |
|-------|----------|---------|
| 0 | out_data | Output values |
| 1 | pin_level | Synchronized pin state, read-only |
| 2 | drive_en | Output enables |
| 3 | route | Interrupt routing |
| 4 | irq_en | Interrupt enables |
| 5 | sense_lvl | Level or edge sensing |
| 6 | sense_pol | Sensing polarity |
| 7 | status | Sticky interrupt status |

The alias codes are 0 (write), 1 (set) and 2 (clear). Code 3 does nothing.

Top module: `gpio_irq_port`

## Requirements
- R1: A write with alias code 0 replaces the whole addressed register with wdata. A read of that register then returns the new value on rdata in the same cycle it is addressed.
- R2: Alias code 1 ORs wdata into the register. Alias code 2 clears every bit that is one in wdata. Alias code 3 leaves the register unchanged.
- R3: Register index 1 (pin_level) returns the pin inputs two clock edges after they change. A change is not yet visible after one edge. Writes to index 1 have no effect.
- R4: pin_out equals out_data (index 0), and pin_oe equals drive_en (index 2), bit for bit.
- R5: The sense of a pin is set by its sense_lvl bit (index 5) and its sense_pol bit (index 6). The pair {lvl,pol} means: 00 falling edge, 01 rising edge, 10 low level, 11 high level.
- R6: A status bit (index 7) stays set until a clear-alias write removes it. In level mode, a cleared bit sets again while the level is still present.
- R7: irq is high exactly when some bit of status AND irq_en (index 4) is one. Clearing the enable or the status bit drops irq.
- R8: A pin whose route bit (index 3) is zero never sets its status bit, whatever its input does.
- R9: After reset every register reads zero, and irq, pin_oe and pin_out are low.
- R10: A detection and a software clear of the same status bit in the same cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 6 | Word address: [5:2] register index, [1:0] alias code |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the register at addr, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output values to the pads |
| pin_oe | output | 32 | Output enables to the pads |
| irq | output | 1 | Combined port interrupt |

## Verification
The assertions check four things on every cycle:
- a status bit never drops unless software wrote the status register;
- no unrouted pin gains a status bit;
- a detection always lands in status, even against a clear;
- irq stays low while status is zero.

They also check the reset state and the effect of a plain write to the output data register.

Only the directed scenarios can show the rest:
- the four sense encodings;
- the two-edge synchronizer latency;
- level re-assertion after a clear;
- the enable gate;
- the three write aliases on each register.

These cases need a chosen sequence of pin changes and register writes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [3:0] {
        IDX_DOUT  = 4'd0,
        IDX_PIN   = 4'd1,
        IDX_OE    = 4'd2,
        IDX_ROUTE = 4'd3,
        IDX_IEN   = 4'd4,
        IDX_LVL   = 4'd5,
        IDX_POL   = 4'd6,
        IDX_STAT  = 4'd7
    } reg_idx_e;

    typedef enum logic [1:0] {
        ACC_WRITE = 2'd0,
        ACC_SET   = 2'd1,
        ACC_CLR   = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] route,
    input  logic [W-1:0] sense_lvl,
    input  logic [W-1:0] sense_pol,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_d, prev_q;

    assign prev_d = level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall, lvl_match, det;
        assign rise      = level[i] & ~prev_q[i];
        assign fall      = ~level[i] & prev_q[i];
        assign lvl_match = ~(level[i] ^ sense_pol[i]);
        assign det       = sense_lvl[i] ? lvl_match : (sense_pol[i] ? rise : fall);
        assign hit[i]    = route[i] & det;
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int N      = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    output logic [N-1:0]      rdata,
    input  logic [N-1:0]      pin_in,
    output logic [N-1:0]      pin_out,
    output logic [N-1:0]      pin_oe,
    output logic              irq
);
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic [N-1:0] dout;
        logic [N-1:0] oe;
        logic [N-1:0] route;
        logic [N-1:0] ien;
        logic [N-1:0] lvl;
        logic [N-1:0] pol;
        logic [N-1:0] stat;
    } regs_t;

    regs_t        r_d, r_q;
    logic [N-1:0] pin_sync;
    logic [N-1:0] hit;
    reg_idx_e     idx;
    acc_e         acc;

    assign idx = reg_idx_e'(addr[5:2]);
    assign acc = acc_e'(addr[1:0]);

    function automatic logic [N-1:0] apply_acc(input logic [N-1:0] cur,
                                               input logic [N-1:0] wd,
                                               input acc_e         a);
        case (a)
            ACC_WRITE: return wd;
            ACC_SET:   return cur | wd;
            ACC_CLR:   return cur & ~wd;
            default:   return cur;
        endcase
    endfunction

    gpio_irq_sync #(.W(N), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_irq_detect #(.W(N)) detect_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (pin_sync),
        .route     (r_q.route),
        .sense_lvl (r_q.lvl),
        .sense_pol (r_q.pol),
        .hit       (hit)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (idx)
                IDX_DOUT:  r_d.dout  = apply_acc(r_q.dout,  wdata, acc);
                IDX_OE:    r_d.oe    = apply_acc(r_q.oe,    wdata, acc);
                IDX_ROUTE: r_d.route = apply_acc(r_q.route, wdata, acc);
                IDX_IEN:   r_d.ien   = apply_acc(r_q.ien,   wdata, acc);
                IDX_LVL:   r_d.lvl   = apply_acc(r_q.lvl,   wdata, acc);
                IDX_POL:   r_d.pol   = apply_acc(r_q.pol,   wdata, acc);
                IDX_STAT:  r_d.stat  = apply_acc(r_q.stat,  wdata, acc);
                default:   ;
            endcase
        end
        // a detection in this cycle overrides any clear of the same bit
        r_d.stat = r_d.stat | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (idx)
            IDX_DOUT:  rdata = r_q.dout;
            IDX_PIN:   rdata = pin_sync;
            IDX_OE:    rdata = r_q.oe;
            IDX_ROUTE: rdata = r_q.route;
            IDX_IEN:   rdata = r_q.ien;
            IDX_LVL:   rdata = r_q.lvl;
            IDX_POL:   rdata = r_q.pol;
            IDX_STAT:  rdata = r_q.stat;
            default:   rdata = '0;
        endcase
    end

    assign pin_out = r_q.dout;
    assign pin_oe  = r_q.oe;
    assign irq     = |(r_q.stat & r_q.ien);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
    parameter int N      = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [N-1:0]      wdata,
    input logic [N-1:0]      pin_out,
    input logic              irq,
    input logic [N-1:0]      stat,
    input logic [N-1:0]      route,
    input logic [N-1:0]      hit
);
    logic stat_wr;
    assign stat_wr = wr_en && (addr[5:2] == 4'd7);

    assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((stat & $past(stat)) == $past(stat)));

    assert_unrouted_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((stat & ~$past(stat) & ~$past(route)) == '0));

    assert_detect_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & $past(hit)) == $past(hit)));

    assert_plain_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0) |=> (pin_out == $past(wdata)));

    assert_no_irq_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == '0) |-> !irq);

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |-> (stat == '0 && !irq && pin_out == '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.N(N), .ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .pin_out (pin_out),
    .irq     (irq),
    .stat    (r_q.stat),
    .route   (r_q.route),
    .hit     (hit)
);

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [5:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out;
    logic [N-1:0] pin_oe;
    logic         irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_port #(.N(N), .ADDR_W(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    localparam logic [3:0] I_DOUT = 0, I_PIN = 1, I_OE = 2, I_ROUTE = 3,
                           I_IEN = 4, I_LVL = 5, I_POL = 6, I_STAT = 7;
    localparam logic [1:0] A_WR = 0, A_SET = 1, A_CLR = 2, A_NONE = 3;

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // every task starts and ends at a falling edge
    task automatic wr(input logic [3:0] idx, input logic [1:0] acc, input logic [N-1:0] d);
        wr_en = 1'b1; addr = {idx, acc}; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [N-1:0] v);
        addr = {idx, 2'b00};
        #1 v = rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [N-1:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(4'(i), v);
            check("R9 reg reset", v, '0);
        end
        check("R9 irq reset", {31'b0, irq}, '0);
        check("R9 pin_oe reset", pin_oe, '0);
        check("R9 pin_out reset", pin_out, '0);
    endtask

    task automatic t_aliases;
        logic [N-1:0] v;
        wr(I_DOUT, A_WR, 32'hA5A5_0F0F);
        rd(I_DOUT, v); check("R1 plain write", v, 32'hA5A5_0F0F);
        wr(I_DOUT, A_WR, 32'h1234_5678);
        rd(I_DOUT, v); check("R1 plain replace", v, 32'h1234_5678);
        wr(I_DOUT, A_SET, 32'h8000_0001);
        rd(I_DOUT, v); check("R2 set alias", v, 32'h9234_5679);
        wr(I_DOUT, A_CLR, 32'h0000_FFFF);
        rd(I_DOUT, v); check("R2 clear alias", v, 32'h9234_0000);
        wr(I_DOUT, A_NONE, 32'hFFFF_FFFF);
        rd(I_DOUT, v); check("R2 alias 3 no effect", v, 32'h9234_0000);
        wr(I_OE, A_SET, 32'hFFFF_0000);
        check("R4 pin_out", pin_out, 32'h9234_0000);
        check("R4 pin_oe", pin_oe, 32'hFFFF_0000);
        wr(I_OE, A_CLR, 32'h0F00_0000);
        check("R4 pin_oe clear", pin_oe, 32'hF0FF_0000);
    endtask

    task automatic t_pin_sync;
        logic [N-1:0] v;
        pin_in = 32'h0000_0000;
        cyc(3);
        pin_in[31:24] = 8'hC3;
        cyc(1);
        rd(I_PIN, v); check("R3 not after one edge", v, 32'h0);
        cyc(1);
        rd(I_PIN, v); check("R3 after two edges", v, 32'hC300_0000);
        wr(I_PIN, A_WR, 32'h0000_FFFF);
        rd(I_PIN, v); check("R3 write ignored", v, 32'hC300_0000);
        pin_in[31:24] = 8'h00;
        cyc(3);
    endtask

    task automatic t_rising;
        logic [N-1:0] v;
        // bit0: lvl=0 pol=1 rising
        wr(I_POL, A_SET, 32'h1);
        wr(I_ROUTE, A_SET, 32'h1);
        wr(I_IEN, A_SET, 32'h1);
        pin_in[0] = 1'b1;
        cyc(2);
        rd(I_STAT, v); check("R5 rising not yet", v & 32'h1, 32'h0);
        cyc(1);
        rd(I_STAT, v); check("R5 rising sets", v & 32'h1, 32'h1);
        check("R7 irq on", {31'b0, irq}, 32'h1);
        pin_in[0] = 1'b0;
        cyc(3);
        rd(I_STAT, v); check("R6 sticky", v & 32'h1, 32'h1);
        wr(I_STAT, A_CLR, 32'h1);
        cyc(2);
        rd(I_STAT, v); check("R6 clear edge", v & 32'h1, 32'h0);
        check("R7 irq off", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_falling;
        logic [N-1:0] v;
        pin_in[1] = 1'b1;
        cyc(3);
        wr(I_ROUTE, A_SET, 32'h2);   // bit1 lvl=0 pol=0 falling
        cyc(2);
        rd(I_STAT, v); check("R5 falling no set on high", v & 32'h2, 32'h0);
        pin_in[1] = 1'b0;
        cyc(3);
        rd(I_STAT, v); check("R5 falling sets", v & 32'h2, 32'h2);
        wr(I_STAT, A_CLR, 32'h2);
    endtask

    task automatic t_level;
        logic [N-1:0] v;
        // bit2 high level {1,1}
        wr(I_LVL, A_SET, 32'h4);
        wr(I_POL, A_SET, 32'h4);
        wr(I_ROUTE, A_SET, 32'h4);
        pin_in[2] = 1'b1;
        cyc(3);
        rd(I_STAT, v); check("R5 high level sets", v & 32'h4, 32'h4);
        wr(I_STAT, A_CLR, 32'h4);
        cyc(1);
        rd(I_STAT, v); check("R6 level re-sets", v & 32'h4, 32'h4);
        pin_in[2] = 1'b0;
        cyc(3);
        wr(I_STAT, A_CLR, 32'h4);
        cyc(1);
        rd(I_STAT, v); check("R6 level gone stays clear", v & 32'h4, 32'h0);
        // bit4 low level {1,0}: pin is low, routing alone raises it
        wr(I_LVL, A_SET, 32'h10);
        wr(I_ROUTE, A_SET, 32'h10);
        cyc(1);
        rd(I_STAT, v); check("R5 low level sets", v & 32'h10, 32'h10);
        wr(I_ROUTE, A_CLR, 32'h10);
        wr(I_STAT, A_CLR, 32'h10);
        cyc(1);
        rd(I_STAT, v); check("R8 unrouted low level", v & 32'h10, 32'h0);
    endtask

    task automatic t_gates;
        logic [N-1:0] v;
        // bit5 rising, enabled, not routed
        wr(I_POL, A_SET, 32'h20);
        wr(I_IEN, A_SET, 32'h20);
        pin_in[5] = 1'b1;
        cyc(4);
        rd(I_STAT, v); check("R8 route gate", v & 32'h20, 32'h0);
        check("R8 no irq", {31'b0, irq}, 32'h0);
        // bit6 rising, routed, not enabled
        wr(I_POL, A_SET, 32'h40);
        wr(I_ROUTE, A_SET, 32'h40);
        pin_in[6] = 1'b1;
        cyc(3);
        rd(I_STAT, v); check("R7 status without enable", v & 32'h40, 32'h40);
        check("R7 irq gated", {31'b0, irq}, 32'h0);
        wr(I_IEN, A_SET, 32'h40);
        check("R7 irq after enable", {31'b0, irq}, 32'h1);
        wr(I_IEN, A_CLR, 32'h40);
        check("R7 irq after disable", {31'b0, irq}, 32'h0);
        wr(I_STAT, A_CLR, 32'h40);
    endtask

    task automatic t_race;
        logic [N-1:0] v;
        // bit3 rising; clear lands on the same edge as the detection
        wr(I_POL, A_SET, 32'h8);
        wr(I_ROUTE, A_SET, 32'h8);
        pin_in[3] = 1'b1;
        cyc(2);
        wr(I_STAT, A_CLR, 32'h8);
        rd(I_STAT, v); check("R10 detection beats clear", v & 32'h8, 32'h8);
        wr(I_STAT, A_CLR, 32'h8);
        rd(I_STAT, v); check("R10 later clear works", v & 32'h8, 32'h0);
    endtask

    initial begin
        cyc(3);
        t_reset();
        rst_n = 1'b1;
        cyc(1);
        t_aliases();
        t_pin_sync();
        t_rising();
        t_falling();
        t_level();
        t_gates();
        t_race();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule